// File: doc/BRIEF.md
# Sync-Pattern Detector and Character Framer

This block takes a stream of 10-bit characters whose character boundary is unknown and finds the timing-reference sequence in it. The sequence is one character of all ones followed by two characters of all zeros: 30 bits that may begin at any of the ten bit positions inside an incoming character. Each cycle, a short history of received characters is tested at every bit position at once. The position that matches goes into an offset register. A barrel shifter uses that register to cut correctly aligned characters out of the history and drives them to a registered output.

Each recognised sequence flips a horizontal-sync flag. The flip comes one cycle before the all-ones character appears at the output, so a downstream parser can prepare for it. With confirmation enabled, one sequence at a new position does not move the framer. It raises a one-cycle sync-error pulse and keeps the old alignment. Only a second misaligned sequence straight after it moves the offset. A transport-mode input, active low, stops the framer from reacting to sequences at all.

Top module: `trs_framer`

## Requirements
- R1: Asynchronous reset (rst_n low) clears dout, hsync and sync_err to 0 and sets the offset register to 0.
- R2: The pattern 3FF, 000, 000 (hex) is detected at every bit offset 0 to 9. Serial order puts din[9] first within a character. Offset k means the pattern starts k bits after din[9] of some character.
- R3: hsync inverts once for each detected pattern. The cycle after the inversion, dout shows 3FF, and the two cycles after that show 000 and 000.
- R4: dout is registered and carries 10 consecutive stream bits taken at the current offset. Characters that follow an aligned pattern come out unchanged on the cycles after the two zero characters.
- R5: With confirm_en low, every detected pattern loads its offset at once, and sync_err stays low.
- R6: With confirm_en high, a pattern at an offset different from the register, with no mismatch pending, leaves the offset unchanged. sync_err goes high for exactly one cycle, in the same cycle that hsync inverts.
- R7: With confirm_en high, if the next pattern after such a held mismatch is also at a differing offset, its offset is loaded (even if it differs from the first mismatch) and sync_err stays low.
- R8: With confirm_en high, a pattern at the current offset cancels a pending mismatch. A later misaligned pattern is then held again, with a sync_err pulse.
- R9: While ts_mode_n is low, detected patterns do not invert hsync, do not pulse sync_err and do not change the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Unaligned received character, din[9] earliest bit |
| confirm_en | input | 1 | Require a second misaligned pattern before realigning |
| ts_mode_n | input | 1 | Low selects transport mode; framer ignores patterns |
| dout | output | 10 | Framed character at the current offset |
| hsync | output | 1 | Flips once per accepted pattern |
| sync_err | output | 1 | One-cycle pulse when a misaligned pattern is held |

## Verification
Patterns are placed at offsets 0, 9 and several middle positions, each followed by known data characters. This shows both that the shifter picks the right bits and that the output lines up with the hsync lead. With confirmation on, the sequences used are mismatch-then-same, mismatch-then-aligned-then-mismatch, and mismatch-then-different-mismatch. These separate holding, loading and clearing of the pending state. A pattern sent in transport mode, followed by a confirmed pattern at the old offset, shows at the ports that the offset was left untouched.

// File: rtl/trs_framer.sv
module trs_framer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         confirm_en,
  input  logic         ts_mode_n,
  output logic [W-1:0] dout,
  output logic         hsync,
  output logic         sync_err
);
  localparam int OW = $clog2(W);
  localparam int HW = 5 * W;
  localparam logic [3*W-1:0] PAT = {{W{1'b1}}, {(2*W){1'b0}}};

  logic [HW-1:0]  hist;
  logic [W-1:0]   hit;
  logic [OW-1:0]  hit_off, off;
  logic [2*W-1:0] pair;
  logic [W-1:0]   frame_c;
  logic           found, trs, moved, pend, take, hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HW-W-1:0], din};

  for (genvar k = 0; k < W; k++) begin : g_scan
    assign hit[k] = (hist[4*W-1-k -: 3*W] == PAT);
  end

  always_comb begin
    hit_off = '0;
    for (int k = W - 1; k >= 0; k--)
      if (hit[k]) hit_off = OW'(k);
  end

  assign found = |hit;
  assign trs   = found & ts_mode_n;
  assign moved = (hit_off != off);
  assign take  = trs & (~confirm_en | ~moved | pend);
  assign hold  = trs & confirm_en & moved & ~pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      off      <= '0;
      hsync    <= 1'b0;
      sync_err <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (trs)  hsync <= ~hsync;
      if (take) off   <= hit_off;
      sync_err <= hold;
      pend     <= ts_mode_n & confirm_en & (trs ? hold : pend);
    end

  assign pair    = hist[HW-1:3*W];
  assign frame_c = pair[2*W-1-int'(off) -: W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout <= '0;
    else        dout <= frame_c;
endmodule

// File: rtl/trs_framer_chk.sv
module trs_framer_chk #(
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          confirm_en,
  input logic          ts_mode_n,
  input logic          hsync,
  input logic          sync_err,
  input logic [OW-1:0] off
);
  // R6
  err_with_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (hsync != $past(hsync)));
  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);
  // R6
  err_keeps_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (off == $past(off)));
  // R5
  err_needs_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(confirm_en));
  // R9
  transport_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ts_mode_n) |-> (hsync == $past(hsync) && off == $past(off) && !sync_err));
endmodule

bind trs_framer trs_framer_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .confirm_en(confirm_en), .ts_mode_n(ts_mode_n),
  .hsync(hsync), .sync_err(sync_err), .off(off)
);

// File: tb/sim_trs_framer.sv
module sim_trs_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       confirm_en = 1'b0;
  logic       ts_mode_n = 1'b1;
  logic [9:0] dout;
  logic       hsync, sync_err;

  trs_framer u0 (.clk(clk), .rst_n(rst_n), .din(din), .confirm_en(confirm_en),
                 .ts_mode_n(ts_mode_n), .dout(dout), .hsync(hsync), .sync_err(sync_err));

  always #10 clk = ~clk;

  int nvec = 0, nmis = 0, cyc = 0;
  bit q[$];
  int nbits = 0;
  bit par = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nmis++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  logic       prev_h = 1'b0;
  int         tog_cnt = 0, err_cnt = 0, cap_i = 6;
  logic [9:0] cap [0:5];

  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_i < 6) begin cap[cap_i] = dout; cap_i++; end
      if (hsync != prev_h) begin tog_cnt++; cap_i = 0; end
      if (sync_err) err_cnt++;
      prev_h = hsync;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_bit(input bit b);
    q.push_back(b);
    nbits++;
  endtask

  task automatic push_alt(input int n);
    for (int i = 0; i < n; i++) begin push_bit(par); par = ~par; end
  endtask

  task automatic push_char(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) push_bit(c[i]);
  endtask

  task automatic play();
    while (q.size() >= 10) begin
      @(negedge clk);
      for (int i = 9; i >= 0; i--) din[i] = q.pop_front();
    end
  endtask

  // One pattern at offset k, followed by three data characters, then idle.
  task automatic send_one(input int k, input int exp_tog, input int exp_err,
                          input bit exp_align, input string req);
    tog_cnt = 0;
    err_cnt = 0;
    push_alt(40);
    while (nbits % 10 != k) push_alt(1);
    push_char(10'h3FF); push_char(10'h000); push_char(10'h000);
    push_char(10'h1C7); push_char(10'h238); push_char(10'h0F0);
    push_alt(80);
    play();
    chk(tog_cnt == exp_tog, {req, " hsync toggles"}, tog_cnt, exp_tog);
    chk(err_cnt == exp_err, {req, " sync_err pulses"}, err_cnt, exp_err);
    if (exp_tog == 1) begin
      if (exp_align) begin
        chk(cap[0] == 10'h3FF, {req, " R3 first char"}, cap[0], 10'h3FF);
        chk(cap[1] == 10'h000 && cap[2] == 10'h000, {req, " R3 zero chars"},
            {cap[1], cap[2]}, 0);
        chk(cap[3] == 10'h1C7 && cap[4] == 10'h238 && cap[5] == 10'h0F0,
            {req, " R4 data chars"}, {cap[3], cap[4], cap[5]}, {10'h1C7, 10'h238, 10'h0F0});
      end else begin
        chk(cap[0] != 10'h3FF, {req, " R6 offset held"}, cap[0], 0);
      end
    end
  endtask

  task automatic t_reset();
    chk(dout == 10'h000, "R1 dout", dout, 0);
    chk(hsync == 1'b0, "R1 hsync", hsync, 0);
    chk(sync_err == 1'b0, "R1 sync_err", sync_err, 0);
    @(negedge clk); rst_n = 1'b1;
    confirm_en = 1'b1;
    send_one(0, 1, 0, 1'b1, "R1 offset zero after reset");
  endtask

  task automatic t_unconfirmed();
    confirm_en = 1'b0;
    send_one(3, 1, 0, 1'b1, "R5 R2 offset 3");
    send_one(7, 1, 0, 1'b1, "R5 R2 offset 7");
  endtask

  task automatic t_hold_confirm();
    confirm_en = 1'b1;
    send_one(7, 1, 0, 1'b1, "R6 aligned");
    send_one(2, 1, 1, 1'b0, "R6 first mismatch");
    send_one(2, 1, 0, 1'b1, "R7 confirmed");
  endtask

  task automatic t_pending_clear();
    confirm_en = 1'b1;
    send_one(5, 1, 1, 1'b0, "R8 mismatch");
    send_one(2, 1, 0, 1'b1, "R8 aligned clears");
    send_one(5, 1, 1, 1'b0, "R8 held again");
    send_one(5, 1, 0, 1'b1, "R8 then confirmed");
  endtask

  task automatic t_new_offset();
    confirm_en = 1'b1;
    send_one(8, 1, 1, 1'b0, "R7 mismatch");
    send_one(1, 1, 0, 1'b1, "R7 second differs");
  endtask

  task automatic t_transport();
    confirm_en = 1'b0;
    ts_mode_n = 1'b0;
    send_one(4, 0, 0, 1'b0, "R9 transport");
    ts_mode_n = 1'b1;
    confirm_en = 1'b1;
    send_one(1, 1, 0, 1'b1, "R9 offset kept");
  endtask

  task automatic t_edges();
    confirm_en = 1'b0;
    send_one(9, 1, 0, 1'b1, "R2 offset 9");
    send_one(0, 1, 0, 1'b1, "R2 offset 0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_unconfirmed();
    t_hold_confirm();
    t_pending_clear();
    t_new_offset();
    t_transport();
    t_edges();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule